// File: doc/BRIEF.md
# Mobile Gateway Ingress Classifier

This block is the first decision point of a mobile user-plane gateway pipeline. For each packet it takes the outer header fields an upstream parser has already pulled out, and it returns one verdict: forward or drop, and which path the packet takes. Tunnelled subscriber traffic goes on the uplink path and is marked for decapsulation. All other traffic goes on the downlink path.

The checks run in a fixed order. First, both outer MAC addresses must be present in their own allow tables. Next, the tunnel test picks the direction. Then the allow-list firewall for that direction is applied to the outer source IP. Last, on uplink only, the tunnel must be addressed to the gateway's own IP. The first check that fails sets the drop reason.

All four tables are exact-match CAMs. Control software loads them through one shared write port. Each packet is accepted on a valid/ready handshake, and its verdict comes back on a registered valid/ready handshake.

Top module: `gw_ingress_classifier`

## Requirements
- R1: After reset, no verdict is valid, `pkt_ready_o` is 1 and every table entry is empty. A packet sent before any table write is therefore dropped with reason 1.
- R2: A packet whose outer source MAC misses the source-MAC table, or whose outer destination MAC misses the destination-MAC table, is dropped with reason 1 and direction 0. The values of all other fields do not matter.
- R3: A packet that passes the MAC checks takes the uplink path (`dir_o` = 1) only when all of these hold: `ipv4_ok_i` = 1, `gtp_ok_i` = 1, UDP destination port 2152, tunnel version 1 and message type 0xFF. Any other packet takes the downlink path (`dir_o` = 0).
- R4: On uplink, the outer source IP must hit the uplink firewall table. On a miss the packet is dropped with reason 2.
- R5: On downlink, the outer source IP must hit the downlink firewall table. On a miss the packet is dropped with reason 2. An entry that is present only in the uplink table does not admit a downlink packet.
- R6: An uplink packet that passes its firewall is dropped with reason 3 when its outer destination IP differs from `own_ip_i`.
- R7: The drop reason is chosen by priority: MAC miss (1) first, then firewall (2), then own-IP mismatch (3).
- R8: For a forwarded uplink packet, `len_o` equals the input length minus 36. For every other verdict, `len_o` equals the input length.
- R9: Each accepted packet produces exactly one verdict, one cycle after it is accepted. `pkt_ready_o` = !`vrd_valid_o` || `vrd_ready_i`. While `vrd_valid_o` = 1 and `vrd_ready_i` = 0, every verdict output holds its value.
- R10: A write with `wr_valid_i` = 1 installs `wr_key_i` at `wr_idx_i` in the table chosen by `wr_tbl_i` (0 source MAC, 1 destination MAC, 2 uplink firewall, 3 downlink firewall). A write with `wr_valid_i` = 0 removes that entry. The change applies to packets accepted in later cycles, not to a packet accepted in the same cycle as the write.
- R11: `drop_o` is 1 exactly when `reason_o` is non-zero. The codes are 0 none, 1 MAC miss, 2 firewall, 3 not own IP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_ip_i | input | 32 | Gateway's own IP address |
| wr_en_i | input | 1 | Table write strobe |
| wr_tbl_i | input | 2 | Table select for the write |
| wr_idx_i | input | IDX_W | Entry index for the write |
| wr_key_i | input | 48 | Key to store (the low 32 bits are used for IP tables) |
| wr_valid_i | input | 1 | Valid bit to store in the entry |
| pkt_valid_i | input | 1 | Packet fields present |
| pkt_ready_o | output | 1 | Packet accepted when high together with valid |
| src_mac_i | input | 48 | Outer source MAC |
| dst_mac_i | input | 48 | Outer destination MAC |
| ipv4_ok_i | input | 1 | Outer IPv4 header is valid |
| src_ip_i | input | 32 | Outer source IP |
| dst_ip_i | input | 32 | Outer destination IP |
| gtp_ok_i | input | 1 | Tunnel header is present |
| udp_dport_i | input | 16 | Outer UDP destination port |
| gtp_ver_i | input | 3 | Tunnel header version |
| gtp_type_i | input | 8 | Tunnel message type |
| len_i | input | LEN_W | Packet length in bytes |
| vrd_valid_o | output | 1 | Verdict present |
| vrd_ready_i | input | 1 | Verdict consumer ready |
| drop_o | output | 1 | Packet is dropped |
| dir_o | output | 1 | 1 uplink, 0 downlink |
| reason_o | output | 2 | Drop reason code |
| len_o | output | LEN_W | Output length |

## Verification
The hardest case to reach is the write/lookup race: a table write and a packet acceptance on the same clock edge. The bench drives both in the same cycle and expects the old table contents. It then resends the packet and expects the new contents.

Back-pressure is the second hard case. The bench holds `vrd_ready_i` low with a second packet waiting, checks that the first verdict stays frozen, and then releases ready. On that edge one verdict leaves and the next packet is accepted.

Each tunnel-qualifying field is spoiled one at a time. The source IP used for this is one that only the uplink firewall admits. A wrong field therefore shows up both as direction 0 and as a firewall drop.

// File: rtl/gwc_pkg.sv
package gwc_pkg;
  localparam logic [15:0] GTP_UDP_PORT  = 16'd2152;
  localparam logic [2:0]  GTP_VERSION   = 3'd1;
  localparam logic [7:0]  GTP_MSG_GPDU  = 8'hFF;
  localparam int unsigned TUN_HDR_BYTES = 36;

  typedef enum logic [1:0] {
    RSN_NONE  = 2'd0,
    RSN_MAC   = 2'd1,
    RSN_FW    = 2'd2,
    RSN_OWNIP = 2'd3
  } reason_e;

  typedef enum logic [1:0] {
    TBL_SMAC = 2'd0,
    TBL_DMAC = 2'd1,
    TBL_UFW  = 2'd2,
    TBL_DFW  = 2'd3
  } tbl_e;
endpackage

// File: rtl/gwc_cam.sv
module gwc_cam #(
  parameter int unsigned KEY_W = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  logic             wr_valid_i,
  input  logic [KEY_W-1:0] lookup_key_i,
  output logic             hit_o
);
  localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

  logic [DEPTH-1:0] match;
  logic             wr_in_range;

  assign wr_in_range = {1'b0, wr_idx_i} < DEPTH_L;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [KEY_W-1:0] key_q;
    logic             vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_q <= '0;
        vld_q <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
        key_q <= wr_key_i;
        vld_q <= wr_valid_i;
      end
    end
    assign match[i] = vld_q && (key_q == lookup_key_i);
  end

  assign hit_o = |match;

  // R10: an entry just installed is found by the next lookup of its key
  a_r10_write_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_valid_i && wr_in_range) |=>
      (lookup_key_i != $past(wr_key_i)) || hit_o);
endmodule

// File: rtl/gwc_decide.sv
module gwc_decide
  import gwc_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             smac_hit_i,
  input  logic             dmac_hit_i,
  input  logic             ipv4_ok_i,
  input  logic             gtp_ok_i,
  input  logic [15:0]      udp_dport_i,
  input  logic [2:0]       gtp_ver_i,
  input  logic [7:0]       gtp_type_i,
  input  logic             ufw_hit_i,
  input  logic             dfw_hit_i,
  input  logic             own_match_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             drop_o,
  output logic             dir_o,
  output reason_e          reason_o,
  output logic [LEN_W-1:0] len_o
);
  logic mac_ok, tunnel;

  assign mac_ok = smac_hit_i && dmac_hit_i;
  assign tunnel = ipv4_ok_i && gtp_ok_i && (udp_dport_i == GTP_UDP_PORT)
                  && (gtp_ver_i == GTP_VERSION) && (gtp_type_i == GTP_MSG_GPDU);

  always_comb begin
    dir_o    = 1'b0;
    reason_o = RSN_NONE;
    len_o    = len_i;
    if (!mac_ok) begin
      reason_o = RSN_MAC;
    end else if (tunnel) begin
      dir_o = 1'b1;
      if (!ufw_hit_i)        reason_o = RSN_FW;
      else if (!own_match_i) reason_o = RSN_OWNIP;
      else                   len_o = len_i - LEN_W'(TUN_HDR_BYTES);
    end else if (!dfw_hit_i) begin
      reason_o = RSN_FW;
    end
    drop_o = (reason_o != RSN_NONE);
  end
endmodule

// File: rtl/gw_ingress_classifier.sv
module gw_ingress_classifier
  import gwc_pkg::*;
#(
  parameter int unsigned MAC_DEPTH = 8,
  parameter int unsigned FW_DEPTH  = 16,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned IDX_W     = $clog2((MAC_DEPTH > FW_DEPTH) ? MAC_DEPTH : FW_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      own_ip_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_tbl_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [47:0]      wr_key_i,
  input  logic             wr_valid_i,
  input  logic             pkt_valid_i,
  output logic             pkt_ready_o,
  input  logic [47:0]      src_mac_i,
  input  logic [47:0]      dst_mac_i,
  input  logic             ipv4_ok_i,
  input  logic [31:0]      src_ip_i,
  input  logic [31:0]      dst_ip_i,
  input  logic             gtp_ok_i,
  input  logic [15:0]      udp_dport_i,
  input  logic [2:0]       gtp_ver_i,
  input  logic [7:0]       gtp_type_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             vrd_valid_o,
  input  logic             vrd_ready_i,
  output logic             drop_o,
  output logic             dir_o,
  output logic [1:0]       reason_o,
  output logic [LEN_W-1:0] len_o
);
  logic [3:0] tbl_we;
  logic       smac_hit, dmac_hit, ufw_hit, dfw_hit;
  logic       accept;

  for (genvar t = 0; t < 4; t++) begin : g_we
    assign tbl_we[t] = wr_en_i && (wr_tbl_i == 2'(t));
  end

  gwc_cam #(.KEY_W(48), .DEPTH(MAC_DEPTH), .IDX_W(IDX_W)) u_smac (
    .clk_i, .rst_ni, .wr_en_i(tbl_we[TBL_SMAC]), .wr_idx_i, .wr_key_i,
    .wr_valid_i, .lookup_key_i(src_mac_i), .hit_o(smac_hit));
  gwc_cam #(.KEY_W(48), .DEPTH(MAC_DEPTH), .IDX_W(IDX_W)) u_dmac (
    .clk_i, .rst_ni, .wr_en_i(tbl_we[TBL_DMAC]), .wr_idx_i, .wr_key_i,
    .wr_valid_i, .lookup_key_i(dst_mac_i), .hit_o(dmac_hit));
  gwc_cam #(.KEY_W(32), .DEPTH(FW_DEPTH), .IDX_W(IDX_W)) u_ufw (
    .clk_i, .rst_ni, .wr_en_i(tbl_we[TBL_UFW]), .wr_idx_i,
    .wr_key_i(wr_key_i[31:0]), .wr_valid_i, .lookup_key_i(src_ip_i), .hit_o(ufw_hit));
  gwc_cam #(.KEY_W(32), .DEPTH(FW_DEPTH), .IDX_W(IDX_W)) u_dfw (
    .clk_i, .rst_ni, .wr_en_i(tbl_we[TBL_DFW]), .wr_idx_i,
    .wr_key_i(wr_key_i[31:0]), .wr_valid_i, .lookup_key_i(src_ip_i), .hit_o(dfw_hit));

  logic             drop_d, dir_d;
  reason_e          reason_d;
  logic [LEN_W-1:0] len_d;

  gwc_decide #(.LEN_W(LEN_W)) u_decide (
    .smac_hit_i(smac_hit), .dmac_hit_i(dmac_hit), .ipv4_ok_i, .gtp_ok_i,
    .udp_dport_i, .gtp_ver_i, .gtp_type_i, .ufw_hit_i(ufw_hit), .dfw_hit_i(dfw_hit),
    .own_match_i(dst_ip_i == own_ip_i), .len_i,
    .drop_o(drop_d), .dir_o(dir_d), .reason_o(reason_d), .len_o(len_d));

  assign pkt_ready_o = !vrd_valid_o || vrd_ready_i;
  assign accept      = pkt_valid_i && pkt_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vrd_valid_o <= 1'b0;
      drop_o      <= 1'b0;
      dir_o       <= 1'b0;
      reason_o    <= 2'd0;
      len_o       <= '0;
    end else if (accept) begin
      vrd_valid_o <= 1'b1;
      drop_o      <= drop_d;
      dir_o       <= dir_d;
      reason_o    <= reason_d;
      len_o       <= len_d;
    end else if (vrd_ready_i) begin
      vrd_valid_o <= 1'b0;
    end
  end

  // R9: verdict frozen under back-pressure
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vrd_valid_o && !vrd_ready_i) |=>
      (vrd_valid_o && $stable(drop_o) && $stable(dir_o) && $stable(reason_o) && $stable(len_o)));

  // R2: MAC miss gives reason 1 on the next verdict
  a_r2_mac_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !(smac_hit && dmac_hit)) |=> (drop_o && reason_o == 2'd1 && !dir_o));

  // R3: qualifying tunnel packets are steered uplink
  a_r3_uplink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && smac_hit && dmac_hit && ipv4_ok_i && gtp_ok_i && udp_dport_i == 16'd2152
     && gtp_ver_i == 3'd1 && gtp_type_i == 8'hFF) |=> dir_o);

  // R6: uplink past firewall with foreign destination is reason 3
  a_r6_own_ip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && smac_hit && dmac_hit && ufw_hit && ipv4_ok_i && gtp_ok_i
     && udp_dport_i == 16'd2152 && gtp_ver_i == 3'd1 && gtp_type_i == 8'hFF
     && dst_ip_i != own_ip_i) |=> (reason_o == 2'd3));

  // R11: drop flag agrees with the reason code
  a_r11_drop_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vrd_valid_o |-> (drop_o == (reason_o != 2'd0)));
endmodule

// File: tb/gw_ingress_classifier_tb.sv
module gw_ingress_classifier_tb;
  localparam int IDX_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] own_ip_i = 32'h0A00_0001;
  logic wr_en_i = 0, wr_valid_i = 0;
  logic [1:0] wr_tbl_i = 0;
  logic [IDX_W-1:0] wr_idx_i = 0;
  logic [47:0] wr_key_i = 0;
  logic pkt_valid_i = 0, pkt_ready_o;
  logic [47:0] src_mac_i = 0, dst_mac_i = 0;
  logic ipv4_ok_i = 0, gtp_ok_i = 0;
  logic [31:0] src_ip_i = 0, dst_ip_i = 0;
  logic [15:0] udp_dport_i = 0;
  logic [2:0] gtp_ver_i = 0;
  logic [7:0] gtp_type_i = 0;
  logic [15:0] len_i = 0;
  logic vrd_valid_o, vrd_ready_i = 1;
  logic drop_o, dir_o;
  logic [1:0] reason_o;
  logic [15:0] len_o;

  int n_chk = 0, n_fail = 0;

  localparam logic [47:0] SMAC = 48'h02_11_22_33_44_55;
  localparam logic [47:0] DMAC = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [31:0] ENB  = 32'hC0A8_0005;
  localparam logic [31:0] INET = 32'h0808_0808;
  localparam logic [31:0] OWN  = 32'h0A00_0001;

  always #2 clk_i = ~clk_i;

  gw_ingress_classifier u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] tbl, input int idx, input logic [47:0] key, input logic v);
    @(negedge clk_i);
    wr_en_i = 1; wr_tbl_i = tbl; wr_idx_i = IDX_W'(idx); wr_key_i = key; wr_valid_i = v;
    @(posedge clk_i); #1 wr_en_i = 0;
  endtask

  task automatic set_pkt(input logic [47:0] sm, input logic [47:0] dm, input logic tun,
                         input logic [31:0] sip, input logic [31:0] dip, input logic [15:0] len);
    src_mac_i = sm; dst_mac_i = dm; src_ip_i = sip; dst_ip_i = dip; len_i = len;
    ipv4_ok_i = 1; gtp_ok_i = tun; udp_dport_i = tun ? 16'd2152 : 16'd80;
    gtp_ver_i = 3'd1; gtp_type_i = 8'hFF;
  endtask

  // fields set beforehand; drive valid, one accept edge, sample next negedge
  task automatic send_and_expect(input string req, input logic d, input logic dir,
                                 input logic [1:0] rsn, input logic [15:0] len);
    @(negedge clk_i);
    pkt_valid_i = 1;
    @(posedge clk_i); #1 pkt_valid_i = 0;
    @(negedge clk_i);
    check({req, " valid"}, 32'(vrd_valid_o), 32'd1);
    check({req, " drop"}, 32'(drop_o), 32'(d));
    check({req, " dir"}, 32'(dir_o), 32'(dir));
    check({req, " reason"}, 32'(reason_o), 32'(rsn));
    check({req, " len"}, 32'(len_o), 32'(len));
  endtask

  task automatic t_reset;
    check("R1 valid after reset", 32'(vrd_valid_o), 0);
    check("R1 ready after reset", 32'(pkt_ready_o), 1);
    set_pkt(SMAC, DMAC, 1, ENB, OWN, 16'd200);
    send_and_expect("R1 empty tables", 1, 0, 2'd1, 16'd200);
  endtask

  task automatic t_load;
    wr(2'd0, 0, SMAC, 1);
    wr(2'd1, 3, DMAC, 1);
    wr(2'd2, 5, {16'h0, ENB}, 1);
    wr(2'd3, 15, {16'h0, INET}, 1);
  endtask

  task automatic t_forward;
    set_pkt(SMAC, DMAC, 1, ENB, OWN, 16'd200);
    send_and_expect("R3 R8 uplink forward", 0, 1, 2'd0, 16'd164);
    set_pkt(SMAC, DMAC, 0, INET, 32'h0A63_0001, 16'd100);
    send_and_expect("R5 R8 downlink forward", 0, 0, 2'd0, 16'd100);
  endtask

  task automatic t_mac;
    set_pkt(48'h1, DMAC, 1, ENB, OWN, 16'd200);
    send_and_expect("R2 src mac miss", 1, 0, 2'd1, 16'd200);
    set_pkt(SMAC, 48'h2, 0, INET, OWN, 16'd90);
    send_and_expect("R2 dst mac miss", 1, 0, 2'd1, 16'd90);
    set_pkt(48'h1, 48'h2, 1, 32'h1, 32'h2, 16'd70);
    send_and_expect("R7 mac before all", 1, 0, 2'd1, 16'd70);
  endtask

  task automatic t_direction;
    // ENB is only in the uplink table, so downlink means firewall drop
    set_pkt(SMAC, DMAC, 1, ENB, OWN, 16'd120); udp_dport_i = 16'd2153;
    send_and_expect("R3 wrong port", 1, 0, 2'd2, 16'd120);
    set_pkt(SMAC, DMAC, 1, ENB, OWN, 16'd120); gtp_ver_i = 3'd2;
    send_and_expect("R3 wrong version", 1, 0, 2'd2, 16'd120);
    set_pkt(SMAC, DMAC, 1, ENB, OWN, 16'd120); gtp_type_i = 8'h01;
    send_and_expect("R3 wrong type", 1, 0, 2'd2, 16'd120);
    set_pkt(SMAC, DMAC, 1, ENB, OWN, 16'd120); ipv4_ok_i = 0;
    send_and_expect("R3 no ipv4", 1, 0, 2'd2, 16'd120);
    set_pkt(SMAC, DMAC, 1, ENB, OWN, 16'd120); gtp_ok_i = 0;
    send_and_expect("R3 R5 no tunnel hdr", 1, 0, 2'd2, 16'd120);
  endtask

  task automatic t_firewall;
    set_pkt(SMAC, DMAC, 1, 32'h0102_0304, OWN, 16'd150);
    send_and_expect("R4 uplink fw miss", 1, 1, 2'd2, 16'd150);
    set_pkt(SMAC, DMAC, 1, 32'h0102_0304, 32'h0A00_0009, 16'd150);
    send_and_expect("R7 fw before own ip", 1, 1, 2'd2, 16'd150);
    set_pkt(SMAC, DMAC, 1, INET, OWN, 16'd150);
    send_and_expect("R4 dl entry not uplink", 1, 1, 2'd2, 16'd150);
  endtask

  task automatic t_own_ip;
    set_pkt(SMAC, DMAC, 1, ENB, 32'h0A00_0002, 16'd180);
    send_and_expect("R6 R8 not own ip", 1, 1, 2'd3, 16'd180);
  endtask

  task automatic t_write_race;
    set_pkt(SMAC, DMAC, 1, 32'hC0A8_0077, OWN, 16'd140);
    @(negedge clk_i);
    wr_en_i = 1; wr_tbl_i = 2'd2; wr_idx_i = 4'd7; wr_key_i = {16'h0, 32'hC0A8_0077}; wr_valid_i = 1;
    pkt_valid_i = 1;
    @(posedge clk_i); #1 begin wr_en_i = 0; pkt_valid_i = 0; end
    @(negedge clk_i);
    check("R10 same cycle sees old", 32'(reason_o), 32'd2);
    send_and_expect("R10 later sees new", 0, 1, 2'd0, 16'd104);
    wr(2'd2, 7, {16'h0, 32'hC0A8_0077}, 0);
    send_and_expect("R10 entry removed", 1, 1, 2'd2, 16'd140);
  endtask

  task automatic t_backpressure;
    set_pkt(SMAC, DMAC, 1, ENB, OWN, 16'd300);
    @(negedge clk_i);
    vrd_ready_i = 0; pkt_valid_i = 1;
    @(posedge clk_i); #1 pkt_valid_i = 0;
    @(negedge clk_i);
    check("R9 first verdict len", 32'(len_o), 32'd264);
    set_pkt(SMAC, DMAC, 0, INET, OWN, 16'd60);
    pkt_valid_i = 1;
    #0 check("R9 not ready when full", 32'(pkt_ready_o), 0);
    repeat (2) @(negedge clk_i);
    check("R9 held valid", 32'(vrd_valid_o), 1);
    check("R9 held len", 32'(len_o), 32'd264);
    check("R9 held dir", 32'(dir_o), 1);
    vrd_ready_i = 1;
    @(posedge clk_i); #1 pkt_valid_i = 0;
    @(negedge clk_i);
    check("R9 second valid", 32'(vrd_valid_o), 1);
    check("R9 second len", 32'(len_o), 32'd60);
    check("R9 R11 second dir", 32'(dir_o), 0);
    @(negedge clk_i);
    check("R9 single verdict", 32'(vrd_valid_o), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1;
        t_reset();
        t_load();
        t_forward();
        t_mac();
        t_direction();
        t_firewall();
        t_own_ip();
        t_write_race();
        t_backpressure();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule